// File: doc/BRIEF.md
# Masked Privileged Control Register File

This block holds the 64-bit privileged control registers of a processor core, each one reached through a 6-bit index. Every index has its own access class: fully writable, masked (only certain bit fields survive a write), cleared by any write, read-only, write-only, or unmapped. An illegal access raises a fault flag instead of moving data. The write-only indices store nothing; a write to one of them produces a single-cycle control pulse that downstream logic (cache flush, interrupt clear, translation-buffer invalidate) acts on.

One index returns a mix of state: its upper half comes from stored bits and its lower half from a free-running cycle counter that starts at zero when reset is released. The write port carries a misspeculation flag; while it is high the write is dropped entirely, with no state change, no pulse and no fault. The read port is combinational; a write becomes visible on the read port in the cycle after the clock edge that takes it.

Top module: `pcr_file`

## Requirements
- R1: After reset, the memory-control register (index 0x02) reads 0x6, and every other readable index, apart from the low half of the cycle-count index, reads zero.
- R2: The vector-base (0x00), memory-control (0x02) and scratch registers (0x20 to 0x20+NSCR-1, NSCR=8 by default) store all 64 written bits.
- R3: Masked indices keep only their masked bits: trap request 0x03 and trap enable 0x04 mask 0xF; priority level 0x05 mask 0x1F; current mode 0x06 and alternate mode 0x07 mask 0x18; software request 0x08 mask 0x7FFF0; instruction control 0x09 mask 0xFF_FFFF_0300; page-table base 0x0A bits 63:30; cache test 0x0B mask 0x1FFB; cache mode 0x0C and miss-queue mode 0x0D mask 0x3F; instruction ASID 0x0E mask 0x7F0; data ASID 0x0F bits 63:57.
- R4: A write of any data to the exception summary (0x10) or exception mask (0x11) leaves that register reading zero.
- R5: A write to a read-only index (interrupt ID 0x12, memory status 0x13, entry staging 0x14) raises wr_fault in the same cycle and changes nothing; reading them returns zero with no fault.
- R6: Reading a write-only index (0x18 data-cache flush, 0x19 instruction-cache flush, 0x1A interrupt clear, 0x1B data-buffer invalidate, 0x1C instruction-buffer invalidate) raises rd_fault; a write to index 0x18+k raises ctl_pulse bit k for exactly the one cycle after the write edge, without wr_fault.
- R7: Any index not listed above faults on read with rd_data zero, and faults on write with no state change.
- R8: The cycle-count index (0x01) reads stored bits 63:32 above the low 32 bits of a counter that is zero during reset and increments on every clock edge after it; a write stores only bits that appear in the upper half.
- R9: While wr_spec is high a write is ignored: no register changes, no pulse and no wr_fault.
- R10: rd_fault implies rd_data is zero, and a fault never coexists with a pulse from the same write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_idx | input | 6 | Read index |
| rd_data | output | 64 | Read data, combinational |
| rd_fault | output | 1 | Illegal read |
| wr_en | input | 1 | Write request |
| wr_spec | input | 1 | Write is on a misspeculated path; suppresses it |
| wr_idx | input | 6 | Write index |
| wr_data | input | 64 | Write data |
| wr_fault | output | 1 | Illegal write, combinational |
| ctl_pulse | output | 5 | One-cycle control pulses from write-only indices |

## Verification
The hardest situation to reach from the ports is a misspeculated write aimed at a write-only or read-only index, where the proof of suppression is the absence of a pulse one cycle later and the absence of a fault in the same cycle. Random traffic with a quarter of writes flagged as speculative covers it, and directed steps force a speculative write to each class followed by a read of the same index. The cycle-count low half is compared every cycle against a counter the bench keeps from reset release.

// File: rtl/pcr_pkg.sv
// Package: index map, access classes, write masks and reset values of the
// privileged control register file. Assumes a 6-bit index and 64-bit data.
package pcr_pkg;

    localparam int IDX_W  = 6;
    localparam int DATA_W = 64;
    localparam int NREG   = 1 << IDX_W;
    localparam int NPULSE = 5;

    localparam int IX_VECBASE = 'h00;
    localparam int IX_CCNT    = 'h01;
    localparam int IX_MEMCTL  = 'h02;
    localparam int IX_TRAPREQ = 'h03;
    localparam int IX_TRAPEN  = 'h04;
    localparam int IX_PRIO    = 'h05;
    localparam int IX_CURMODE = 'h06;
    localparam int IX_ALTMODE = 'h07;
    localparam int IX_SWREQ   = 'h08;
    localparam int IX_ICTL    = 'h09;
    localparam int IX_PTBASE  = 'h0A;
    localparam int IX_DCTEST  = 'h0B;
    localparam int IX_CMODE   = 'h0C;
    localparam int IX_MQMODE  = 'h0D;
    localparam int IX_IASID   = 'h0E;
    localparam int IX_DASID   = 'h0F;
    localparam int IX_EXCSUM  = 'h10;
    localparam int IX_EXCMSK  = 'h11;
    localparam int IX_INTID   = 'h12;
    localparam int IX_MSTAT   = 'h13;
    localparam int IX_STAGE   = 'h14;
    localparam int IX_PULSE0  = 'h18;
    localparam int IX_SCR0    = 'h20;

    typedef enum logic [2:0] {K_NONE, K_RW, K_CLR, K_RO, K_WO} kind_t;

    // Access class of an index.
    function automatic kind_t reg_kind(int idx, int nscr);
        if (idx >= IX_SCR0 && idx < IX_SCR0 + nscr) return K_RW;
        if (idx >= IX_PULSE0 && idx < IX_PULSE0 + NPULSE) return K_WO;
        if (idx >= IX_VECBASE && idx <= IX_DASID) return K_RW;
        if (idx == IX_EXCSUM || idx == IX_EXCMSK) return K_CLR;
        if (idx >= IX_INTID && idx <= IX_STAGE) return K_RO;
        return K_NONE;
    endfunction

    // Bits of a write that a register keeps.
    function automatic logic [DATA_W-1:0] reg_mask(int idx);
        case (idx)
            IX_TRAPREQ, IX_TRAPEN:  return 64'hF;
            IX_PRIO:                return 64'h1F;
            IX_CURMODE, IX_ALTMODE: return 64'h18;
            IX_SWREQ:               return 64'h7_FFF0;
            IX_ICTL:                return 64'hFF_FFFF_0300;
            IX_PTBASE:              return 64'hFFFF_FFFF_C000_0000;
            IX_DCTEST:              return 64'h1FFB;
            IX_CMODE, IX_MQMODE:    return 64'h3F;
            IX_IASID:               return 64'h7F0;
            IX_DASID:               return 64'hFE00_0000_0000_0000;
            default:                return '1;
        endcase
    endfunction

    // Value a register takes at reset.
    function automatic logic [DATA_W-1:0] reg_reset(int idx);
        return (idx == IX_MEMCTL) ? 64'h6 : '0;
    endfunction

endpackage

// File: rtl/pcr_cyc_counter.sv
// Free-running cycle counter. Holds zero during reset and adds one on every
// clock edge afterwards; wraps silently. Assumes CNT_W >= 32.
module pcr_cyc_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt
);
    // Count every clock once reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pcr_store.sv
// Register storage. One generate slice per index builds a masked flop for
// writable and clear-on-write classes and a zero constant for the rest.
// Write-only indices drive registered one-cycle pulses. Assumes wr_acc is
// already gated by the misspeculation flag.
module pcr_store
    import pcr_pkg::*;
#(
    parameter int NSCR = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_acc,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [DATA_W-1:0]           wr_data,
    output logic [NREG-1:0][DATA_W-1:0] regs_q,
    output logic [NPULSE-1:0]           pulse_q
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam kind_t            KIND = reg_kind(g, NSCR);
        localparam logic [DATA_W-1:0] MASK = reg_mask(g);
        localparam logic [DATA_W-1:0] RSTV = reg_reset(g);
        if (KIND == K_RW || KIND == K_CLR) begin : g_flop
            logic hit;
            assign hit = wr_acc && (wr_idx == IDX_W'(g));
            // Capture the masked write, or clear on a clear-class write.
            always_ff @(posedge clk) begin
                if (!rst_n)   regs_q[g] <= RSTV;
                else if (hit) regs_q[g] <= (KIND == K_CLR) ? '0 : (wr_data & MASK);
            end
        end else begin : g_zero
            assign regs_q[g] = '0;
        end
    end

    for (genvar p = 0; p < NPULSE; p++) begin : g_pulse
        // Raise the control pulse for one cycle after a write to its index.
        always_ff @(posedge clk) begin
            if (!rst_n) pulse_q[p] <= 1'b0;
            else        pulse_q[p] <= wr_acc && (wr_idx == IDX_W'(IX_PULSE0 + p));
        end
    end
endmodule

// File: rtl/pcr_read_mux.sv
// Combinational read port. Selects the stored value, splices the live
// counter into the cycle-count index, and faults on write-only or unmapped
// indices with zero data. Assumes CNT_W >= 32.
module pcr_read_mux
    import pcr_pkg::*;
#(
    parameter int NSCR  = 8,
    parameter int CNT_W = 32
) (
    input  logic [IDX_W-1:0]            rd_idx,
    input  logic [NREG-1:0][DATA_W-1:0] regs_q,
    input  logic [CNT_W-1:0]            cnt,
    output logic [DATA_W-1:0]           rd_data,
    output logic                        rd_fault
);
    kind_t kind;
    assign kind = reg_kind(int'(rd_idx), NSCR);

    // Pick data and fault flag for the addressed index.
    always_comb begin
        rd_fault = 1'b0;
        rd_data  = regs_q[rd_idx];
        if (kind == K_WO || kind == K_NONE) begin
            rd_fault = 1'b1;
            rd_data  = '0;
        end else if (int'(rd_idx) == IX_CCNT) begin
            rd_data = {regs_q[rd_idx][DATA_W-1:32], cnt[31:0]};
        end
    end
endmodule

// File: rtl/pcr_file.sv
// Top of the privileged control register file. Gates writes with the
// misspeculation flag, flags illegal writes, and ties storage, counter and
// read port together. Assumes synchronous active-low reset.
module pcr_file
    import pcr_pkg::*;
#(
    parameter int NSCR  = 8,
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_fault,
    input  logic              wr_en,
    input  logic              wr_spec,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_fault,
    output logic [NPULSE-1:0] ctl_pulse
);
    logic                        wr_acc;
    logic                        wr_bad;
    kind_t                       wkind;
    logic [NREG-1:0][DATA_W-1:0] regs_q;
    logic [CNT_W-1:0]            cnt;

    assign wkind  = reg_kind(int'(wr_idx), NSCR);
    assign wr_bad = (wkind == K_RO) || (wkind == K_NONE);
    // A write counts only off the misspeculated path and to a legal index.
    assign wr_acc   = wr_en && !wr_spec && !wr_bad;
    assign wr_fault = wr_en && !wr_spec && wr_bad;

    pcr_cyc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cnt)
    );

    pcr_store #(.NSCR(NSCR)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_acc  (wr_acc),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .regs_q  (regs_q),
        .pulse_q (ctl_pulse)
    );

    pcr_read_mux #(.NSCR(NSCR), .CNT_W(CNT_W)) u_rd (
        .rd_idx   (rd_idx),
        .regs_q   (regs_q),
        .cnt      (cnt),
        .rd_data  (rd_data),
        .rd_fault (rd_fault)
    );
endmodule

// File: rtl/pcr_file_chk.sv
// Checker for pcr_file: port-level temporal properties, bound to the top.
module pcr_file_chk
    import pcr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [IDX_W-1:0]  rd_idx,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_fault,
    input logic              wr_en,
    input logic              wr_spec,
    input logic [IDX_W-1:0]  wr_idx,
    input logic              wr_fault,
    input logic [NPULSE-1:0] ctl_pulse
);
    logic seen;
    // Mark cycles whose previous edge was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    AST_FAULT_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fault |-> rd_data == '0);                                        // R7
    AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctl_pulse));                                               // R6
    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && ctl_pulse != '0) |-> $past(wr_en && !wr_spec && !wr_fault)); // R10
    AST_SPEC_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_spec |-> !wr_fault);                                             // R9
    AST_SPEC_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_spec) |=> ctl_pulse == '0);                            // R9
    AST_EXC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_spec && (int'(wr_idx) == IX_EXCSUM) && (int'(rd_idx) == IX_EXCSUM))
        |=> (int'(rd_idx) != IX_EXCSUM || rd_data == '0));                   // R4
    AST_PRIO_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_idx) == IX_PRIO) |-> rd_data[DATA_W-1:5] == '0);           // R3
    AST_CCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && int'(rd_idx) == IX_CCNT && int'($past(rd_idx)) == IX_CCNT)
        |-> rd_data[31:0] == $past(rd_data[31:0]) + 32'd1);                 // R8
endmodule

bind pcr_file pcr_file_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .rd_fault  (rd_fault),
    .wr_en     (wr_en),
    .wr_spec   (wr_spec),
    .wr_idx    (wr_idx),
    .wr_fault  (wr_fault),
    .ctl_pulse (ctl_pulse)
);

// File: tb/pcr_file_bench.sv
`timescale 1ns/1ps
module pcr_file_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  rd_idx = '0;
    logic [63:0] rd_data;
    logic        rd_fault;
    logic        wr_en = 1'b0;
    logic        wr_spec = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic        wr_fault;
    logic [4:0]  ctl_pulse;

    int total = 0;
    int bad = 0;
    logic [63:0] model [64];
    logic [4:0]  exp_pulse = '0;
    logic [31:0] tb_cyc = '0;

    pcr_file u_pcr_file (
        .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_data(rd_data),
        .rd_fault(rd_fault), .wr_en(wr_en), .wr_spec(wr_spec),
        .wr_idx(wr_idx), .wr_data(wr_data), .wr_fault(wr_fault),
        .ctl_pulse(ctl_pulse)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) tb_cyc <= '0;
        else        tb_cyc <= tb_cyc + 32'd1;
    end

    // 0 none, 1 rw, 2 clear, 3 read-only, 4 write-only
    function automatic int bkind(int i);
        if (i >= 'h20 && i <= 'h27) return 1;
        if (i >= 'h18 && i <= 'h1C) return 4;
        if (i <= 'h0F) return 1;
        if (i == 'h10 || i == 'h11) return 2;
        if (i >= 'h12 && i <= 'h14) return 3;
        return 0;
    endfunction

    function automatic logic [63:0] bmask(int i);
        if (i == 3 || i == 4) return 64'hF;
        if (i == 5) return 64'h1F;
        if (i == 6 || i == 7) return 64'h18;
        if (i == 8) return 64'h7FFF0;
        if (i == 9) return 64'hFF_FFFF_0300;
        if (i == 10) return {34'h3_FFFF_FFFF, 30'h0};
        if (i == 11) return 64'h1FFB;
        if (i == 12 || i == 13) return 64'h3F;
        if (i == 14) return 64'h7F0;
        if (i == 15) return {7'h7F, 57'h0};
        return '1;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive, check combinational outputs, then take the edge.
    task automatic step(input int ri, input bit we, input bit ws, input int wi,
                        input logic [63:0] wd, input string req);
        logic [63:0] er;
        bit ef, ewf;
        int k;
        @(negedge clk);
        rd_idx = 6'(ri); wr_en = we; wr_spec = ws; wr_idx = 6'(wi); wr_data = wd;
        #1;
        k = bkind(ri);
        ef = (k == 0 || k == 4);
        er = ef ? 64'h0 : model[ri];
        if (ri == 1) er = {model[1][63:32], tb_cyc};
        chk(rd_fault == ef, {req, " rd_fault"}, 64'(rd_fault), 64'(ef));
        chk(rd_data == er, {req, " rd_data"}, rd_data, er);
        chk(ctl_pulse == exp_pulse, "R6 pulse", 64'(ctl_pulse), 64'(exp_pulse));
        ewf = we && !ws && (bkind(wi) == 0 || bkind(wi) == 3);
        chk(wr_fault == ewf, "R5/R7/R9 wr_fault", 64'(wr_fault), 64'(ewf));
        @(posedge clk);
        exp_pulse = '0;
        if (we && !ws) begin
            k = bkind(wi);
            if (k == 1) model[wi] = wd & bmask(wi);
            else if (k == 2) model[wi] = '0;
            else if (k == 4) exp_pulse = 5'(1 << (wi - 'h18));
        end
    endtask

    initial begin
        #(200000 * 8);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 64; i++) model[i] = '0;
        model[2] = 64'h6;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values of every index, counter low half included (R8)
        for (int i = 0; i < 64; i++) step(i, 0, 0, 0, 0, "R1");
        // R2: full-width registers
        step(0, 1, 0, 'h00, 64'hDEAD_BEEF_0123_4567, "R2");
        step(0, 1, 0, 'h02, 64'hFFFF_FFFF_FFFF_FFFF, "R2");
        step(2, 1, 0, 'h27, 64'h8000_0000_0000_0001, "R2");
        step('h27, 0, 0, 0, 0, "R2");
        // R3: all-ones then read each masked register
        for (int i = 3; i <= 15; i++) begin
            step(i, 1, 0, i, '1, "R3");
            step(i, 0, 0, 0, 0, "R3");
        end
        // R4: clear on write
        step('h10, 1, 0, 'h10, '1, "R4");
        step('h10, 1, 0, 'h11, 64'h1234, "R4");
        step('h11, 0, 0, 0, 0, "R4");
        // R5: read-only writes fault
        step('h12, 1, 0, 'h12, '1, "R5");
        step('h12, 1, 0, 'h14, '1, "R5");
        step('h14, 0, 0, 0, 0, "R5");
        // R6: write-only pulses and read faults
        for (int i = 'h18; i <= 'h1C; i++) step(i, 1, 0, i, '1, "R6");
        step('h1C, 0, 0, 0, 0, "R6");
        // R7: unmapped
        step('h3F, 1, 0, 'h3F, '1, "R7");
        step('h15, 1, 0, 'h2F, '1, "R7");
        // R8: cycle count upper half write
        step(1, 1, 0, 'h01, 64'hCAFE_F00D_FFFF_FFFF, "R8");
        step(1, 0, 0, 0, 0, "R8");
        step(1, 0, 0, 0, 0, "R8");
        // R9: speculative writes to each class are dropped
        step(0, 1, 1, 'h20, '1, "R9");
        step('h20, 1, 1, 'h18, '1, "R9");
        step('h18, 1, 1, 'h12, '1, "R9");
        step('h10, 1, 1, 'h3F, '1, "R9");
        step('h05, 1, 1, 'h05, '1, "R9");
        // R10: random mix
        for (int n = 0; n < 600; n++) begin
            step(int'($urandom_range(0, 63)), ($urandom_range(0, 3) != 0),
                 ($urandom_range(0, 3) == 0), int'($urandom_range(0, 63)),
                 {$urandom, $urandom}, "R10");
        end
        step(0, 0, 0, 0, 0, "R10");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule